// File: doc/BRIEF.md
# NAND Prefetch and Write-Post Engine

This block is one shared engine that moves a programmed number of bytes between a NAND device and a 64-byte internal FIFO. It works in one of two directions. In prefetch mode it reads bytes from the device into the FIFO, and the CPU drains them. In write-post mode the CPU fills the FIFO and the engine hands the bytes to the device. Only one transfer can run at a time. The control word therefore reads nonzero while the engine is busy, and software uses that to arbitrate between chip selects.

The CPU sees four 32-bit registers, selected by a 2-bit address: 0 is configuration, 1 is byte count, 2 is control and 3 is status. Data bytes pass through a separate byte-wide push and pop port. On the device side, a request/acknowledge handshake stands in for the external memory bus. Each cycle in which request and acknowledge are both high moves one byte. In DMA mode, a request output tells a DMA controller that enough bytes, or enough free space, are waiting in the FIFO. When the programmed count has been moved, the engine goes idle by itself and raises a one-cycle done pulse.

Top module: `nand_pfwp_engine`

## Requirements
- R1: After reset the configuration, count, control and status registers all read 0, and `dma_req`, `done` and `dev_req` are low.
- R2: The configuration word (address 0) holds the enable bit at bit 7, DMA mode at bit 2, direction at bit 0 (0 = prefetch read, 1 = write-post), chip select at bits 26:24 and FIFO threshold at bits 14:8. All other bits read 0. The chip select drives `dev_cs` and the direction drives `dev_dir`.
- R3: A threshold above 64 is stored and read back as 64.
- R4: Writes to configuration or count (address 1) while the engine is busy leave those registers unchanged.
- R5: Writing 1 to control bit 0 (address 2) starts the engine and loads the remaining count from the count register, but only if the engine is enabled and the count is nonzero. Otherwise the write is ignored. While the engine runs, control reads 1.
- R6: In prefetch mode, `dev_req` is high only while busy and the FIFO is not full. Bytes from the device reach the CPU pop port in arrival order, and a push into a full FIFO is dropped.
- R7: In write-post mode, bytes pushed by the CPU appear on `dev_wbyte` in push order. `dev_req` is high only while busy and the FIFO is not empty.
- R8: Status bits 13:0 (address 3) give the bytes still to move. The value drops by one for each handshake with both `dev_req` and `dev_ack` high.
- R9: Status bits 30:24 give the FIFO level in prefetch mode and 64 minus the level in write-post mode.
- R10: When the remaining count reaches 0, the busy flag clears by itself and `done` is high for exactly one cycle. No further device transfers follow.
- R11: Writing 0 to control stops the engine with no done pulse. A configuration write with bit 7 clear while idle empties the FIFO.
- R12: `dma_req` is high exactly when the engine is enabled and in DMA mode and either of these holds: in prefetch mode the level is at least the threshold, or in write-post mode the free space is at least the threshold.
- R13: In prefetch mode, a CPU pop and a device byte in the same cycle leave the FIFO level unchanged and lose neither byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cpu_push | input | 1 | CPU writes a byte into the FIFO (write-post mode) |
| cpu_wbyte | input | 8 | Byte pushed by the CPU |
| cpu_pop | input | 1 | CPU takes a byte from the FIFO (prefetch mode) |
| cpu_rbyte | output | 8 | Oldest FIFO byte |
| dev_req | output | 1 | Engine is ready to move one byte with the device |
| dev_dir | output | 1 | 0 = device to FIFO, 1 = FIFO to device |
| dev_cs | output | 3 | Selected chip |
| dev_ack | input | 1 | Device completes the byte this cycle |
| dev_rbyte | input | 8 | Byte from the device |
| dev_wbyte | output | 8 | Byte to the device |
| dma_req | output | 1 | Threshold-driven DMA request |
| done | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
In prefetch mode, the CPU pop and the device push can land on the same FIFO in the same clock edge. The bench provokes this by raising `cpu_pop` and `dev_ack` together for one cycle while the FIFO holds three bytes. It then expects the status FIFO field to stay at 3 and the remaining count to drop by one. The popped byte is compared against the scoreboard head, and the incoming byte is compared later in its turn. A second collision is the final device transfer meeting the automatic busy clear. That case is judged by counting the cycles `done` is high and confirming that the remaining count and FIFO level stay frozen while `dev_ack` is still held.

// File: rtl/nand_pfwp_pkg.sv
package nand_pfwp_pkg;

    localparam logic [1:0] A_CFG  = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_CTL  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    localparam int CFG_EN_BIT    = 7;
    localparam int CFG_DMA_BIT   = 2;
    localparam int CFG_DIR_BIT   = 0;
    localparam int CFG_CS_LSB    = 24;
    localparam int CFG_TH_LSB    = 8;
    localparam int STAT_FIFO_LSB = 24;
    localparam int CS_W          = 3;
    localparam int TH_W          = 7;

    typedef enum logic {
        DIR_PREFETCH = 1'b0,
        DIR_POST     = 1'b1
    } dir_e;

    typedef struct packed {
        logic [CS_W-1:0] cs;
        logic [TH_W-1:0] thresh;
        logic            en;
        logic            dma;
        dir_e            dir;
    } cfg_t;

    function automatic cfg_t cfg_decode(input logic [31:0] w, input int depth);
        cfg_t c;
        c.cs     = w[CFG_CS_LSB +: CS_W];
        c.thresh = w[CFG_TH_LSB +: TH_W];
        if (int'(c.thresh) > depth) begin
            c.thresh = TH_W'(depth);
        end
        c.en  = w[CFG_EN_BIT];
        c.dma = w[CFG_DMA_BIT];
        c.dir = dir_e'(w[CFG_DIR_BIT]);
        return c;
    endfunction

    function automatic logic [31:0] cfg_encode(input cfg_t c);
        logic [31:0] w;
        w = '0;
        w[CFG_CS_LSB +: CS_W] = c.cs;
        w[CFG_TH_LSB +: TH_W] = c.thresh;
        w[CFG_EN_BIT]         = c.en;
        w[CFG_DMA_BIT]        = c.dma;
        w[CFG_DIR_BIT]        = c.dir;
        return w;
    endfunction

endpackage

// File: rtl/nand_pfwp_fifo.sv
module nand_pfwp_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= ptr_next(wp);
            if (do_pop)  rp <= ptr_next(rp);
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> $stable(level));

    p_same_cycle_r13: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !full && !empty && !flush) |=> $stable(level));

    p_level_bound_r9: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

endmodule

// File: rtl/nand_pfwp_regs.sv
module nand_pfwp_regs
    import nand_pfwp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNTW  = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [31:0]     wdata,
    input  logic            xfer,
    output cfg_t            cfg,
    output logic            busy,
    output logic [CNTW-1:0] total,
    output logic [CNTW-1:0] remaining,
    output logic            done,
    output logic            flush
);
    logic cfg_wr, cnt_wr, ctl_wr;

    assign cfg_wr = wr_en && (addr == A_CFG);
    assign cnt_wr = wr_en && (addr == A_CNT);
    assign ctl_wr = wr_en && (addr == A_CTL);
    assign flush  = cfg_wr && !busy && !wdata[CFG_EN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            total     <= '0;
            remaining <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy && xfer) begin
                remaining <= remaining - 1'b1;
                if (remaining == CNTW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
            if (cfg_wr && !busy) begin
                cfg <= cfg_decode(wdata, DEPTH);
            end
            if (cnt_wr && !busy) begin
                total <= wdata[CNTW-1:0];
            end
            if (ctl_wr) begin
                if (!wdata[0]) begin
                    busy <= 1'b0;
                end else if (!busy && cfg.en && (total != '0)) begin
                    busy      <= 1'b1;
                    remaining <= total;
                end
            end
        end
    end

    p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(cfg) && $stable(total)));

    p_busy_has_work_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> (remaining != '0));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_start_load_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (remaining == total));

endmodule

// File: rtl/nand_pfwp_engine.sv
module nand_pfwp_engine
    import nand_pfwp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNTW  = 14
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cpu_push,
    input  logic [7:0]  cpu_wbyte,
    input  logic        cpu_pop,
    output logic [7:0]  cpu_rbyte,
    output logic        dev_req,
    output logic        dev_dir,
    output logic [2:0]  dev_cs,
    input  logic        dev_ack,
    input  logic [7:0]  dev_rbyte,
    output logic [7:0]  dev_wbyte,
    output logic        dma_req,
    output logic        done
);
    localparam int LW = $clog2(DEPTH + 1);

    cfg_t            cfg;
    logic            busy, flush, xfer;
    logic [CNTW-1:0] total, remaining;
    logic [LW-1:0]   level, free_sp, fifo_field;
    logic            full, empty, f_push, f_pop;
    logic [7:0]      f_din, f_dout;
    logic            post;

    assign post = (cfg.dir == DIR_POST);
    assign xfer = dev_req && dev_ack;

    nand_pfwp_regs #(.DEPTH(DEPTH), .CNTW(CNTW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .xfer(xfer), .cfg(cfg), .busy(busy),
        .total(total), .remaining(remaining), .done(done), .flush(flush)
    );

    assign f_push = post ? cpu_push : xfer;
    assign f_din  = post ? cpu_wbyte : dev_rbyte;
    assign f_pop  = post ? xfer : cpu_pop;

    nand_pfwp_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst(rst), .flush(flush), .push(f_push), .din(f_din),
        .pop(f_pop), .dout(f_dout), .level(level), .full(full), .empty(empty)
    );

    assign free_sp    = LW'(DEPTH) - level;
    assign fifo_field = post ? free_sp : level;

    assign dev_req   = busy && (post ? !empty : !full);
    assign dev_dir   = cfg.dir;
    assign dev_cs    = cfg.cs;
    assign dev_wbyte = f_dout;
    assign cpu_rbyte = f_dout;
    assign dma_req   = cfg.en && cfg.dma && (fifo_field >= LW'(cfg.thresh));

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG: reg_rdata = cfg_encode(cfg);
            A_CNT: reg_rdata[CNTW-1:0] = total;
            A_CTL: reg_rdata[0] = busy;
            default: begin
                reg_rdata[CNTW-1:0]           = remaining;
                reg_rdata[STAT_FIFO_LSB +: LW] = fifo_field;
            end
        endcase
    end

    p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
        (xfer && !(reg_wr_en && reg_addr == A_CTL))
        |=> (remaining == $past(remaining) - 1'b1));

endmodule

// File: tb/nand_pfwp_engine_test.sv
module nand_pfwp_engine_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_push = 1'b0;
    logic [7:0]  cpu_wbyte = '0;
    logic        cpu_pop = 1'b0;
    logic [7:0]  cpu_rbyte;
    logic        dev_req, dev_dir, dev_ack = 1'b0;
    logic [2:0]  dev_cs;
    logic [7:0]  dev_rbyte, dev_wbyte;
    logic        dma_req, done;

    int n_chk = 0;
    int n_err = 0;
    int done_cnt = 0;
    logic [7:0] rq[$];
    logic [7:0] wq[$];
    logic [31:0] v;

    always #2.5 clk = ~clk;

    nand_pfwp_engine uut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_push(cpu_push),
        .cpu_wbyte(cpu_wbyte), .cpu_pop(cpu_pop), .cpu_rbyte(cpu_rbyte),
        .dev_req(dev_req), .dev_dir(dev_dir), .dev_cs(dev_cs), .dev_ack(dev_ack),
        .dev_rbyte(dev_rbyte), .dev_wbyte(dev_wbyte), .dma_req(dma_req), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // device model: new byte after each read-direction handshake
    always @(posedge clk) begin
        if (rst) dev_rbyte <= 8'h11;
        else if (dev_req && dev_ack && !dev_dir) dev_rbyte <= dev_rbyte + 8'd37;
    end

    // monitor: records device bytes, compares posted bytes, counts done cycles
    always @(negedge clk) begin
        if (!rst) begin
            if (done) done_cnt++;
            if (dev_req && dev_ack) begin
                if (!dev_dir) rq.push_back(dev_rbyte);
                else if (wq.size() == 0) chk("R7 unexpected device write", {24'd0, dev_wbyte}, 32'hFFFF_FFFF);
                else chk("R7 write-post byte order", {24'd0, dev_wbyte}, {24'd0, wq.pop_front()});
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(posedge clk); #1 reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        @(negedge clk); d = reg_rdata;
        @(posedge clk); #1;
    endtask

    task automatic cpu_read(input string tag);
        chk(tag, {24'd0, cpu_rbyte}, (rq.size() > 0) ? {24'd0, rq.pop_front()} : 32'hFFFF_FFFF);
        cpu_pop = 1'b1;
        @(posedge clk); #1 cpu_pop = 1'b0;
    endtask

    task automatic cpu_write(input logic [7:0] b);
        cpu_wbyte = b; cpu_push = 1'b1; wq.push_back(b);
        @(posedge clk); #1 cpu_push = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300; i++) begin
            rd(2'd2, v);
            if (v == 32'd0) break;
        end
    endtask

    initial begin
        #(5 * 150000);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        rd(2'd0, v); chk("R1 config after reset", v, 0);
        rd(2'd1, v); chk("R1 count after reset", v, 0);
        rd(2'd2, v); chk("R1 control after reset", v, 0);
        rd(2'd3, v); chk("R1 status after reset", v, 0);
        chk("R1 outputs low", {29'd0, dma_req, done, dev_req}, 0);

        // R2 field layout and R3 clamp
        wr(2'd0, 32'h0500_1480);
        rd(2'd0, v); chk("R2 config readback", v, 32'h0500_1480);
        chk("R2 dev_cs", {29'd0, dev_cs}, 5);
        chk("R2 dev_dir", {31'd0, dev_dir}, 0);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R2 R3 all-ones readback with threshold clamp", v, 32'h0700_4085);
        wr(2'd0, 32'h0000_6480);
        rd(2'd0, v); chk("R3 threshold 100 clamps to 64", v, 32'h0000_4080);

        // prefetch read: cs 2, threshold 4, DMA, enabled
        wr(2'd0, 32'h0200_0484);
        wr(2'd1, 32'd10);
        wr(2'd2, 32'd1);
        rd(2'd2, v); chk("R5 control busy after start", v, 1);
        rd(2'd3, v); chk("R5 remaining loaded", {18'd0, v[13:0]}, 10);
        wr(2'd1, 32'd99);
        rd(2'd1, v); chk("R4 count write ignored while busy", v, 10);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R4 config write ignored while busy", v, 32'h0200_0484);
        chk("R12 no dma below threshold", {31'd0, dma_req}, 0);
        chk("R6 dev_req while busy and not full", {31'd0, dev_req}, 1);

        dev_ack = 1'b1;
        repeat (4) @(posedge clk);
        #1 dev_ack = 1'b0;
        rd(2'd3, v);
        chk("R8 remaining after 4 bytes", {18'd0, v[13:0]}, 6);
        chk("R9 read-mode fifo count", {25'd0, v[30:24]}, 4);
        chk("R12 dma at threshold in read mode", {31'd0, dma_req}, 1);
        cpu_read("R6 first prefetched byte");
        chk("R12 dma drops below threshold", {31'd0, dma_req}, 0);

        // R13: pop and device push in the same cycle
        chk("R13 popped byte", {24'd0, cpu_rbyte}, {24'd0, rq.pop_front()});
        cpu_pop = 1'b1; dev_ack = 1'b1;
        @(posedge clk); #1 cpu_pop = 1'b0; dev_ack = 1'b0;
        rd(2'd3, v);
        chk("R13 level unchanged", {25'd0, v[30:24]}, 3);
        chk("R13 R8 remaining decremented", {18'd0, v[13:0]}, 5);

        dev_ack = 1'b1;
        wait_idle();
        repeat (3) @(posedge clk);
        #1;
        rd(2'd3, v);
        dev_ack = 1'b0;
        chk("R10 single done pulse", done_cnt, 1);
        chk("R10 remaining zero", {18'd0, v[13:0]}, 0);
        chk("R10 no transfer after done", {25'd0, v[30:24]}, 8);
        for (int i = 0; i < 6; i++) cpu_read("R6 prefetched byte order");

        // R11 flush on disable
        wr(2'd0, 32'h0);
        wr(2'd0, 32'h0000_0080);
        rd(2'd3, v); chk("R11 fifo emptied by disable", {25'd0, v[30:24]}, 0);
        rq.delete();

        // write-post: cs 1, threshold 60, DMA, enabled
        wr(2'd0, 32'h0100_3C85);
        rd(2'd3, v); chk("R9 write-mode free count empty fifo", {25'd0, v[30:24]}, 64);
        chk("R12 dma on free space", {31'd0, dma_req}, 1);
        chk("R2 dev_cs write mode", {29'd0, dev_cs}, 1);
        for (int i = 0; i < 5; i++) cpu_write(8'hA0 + 8'(i * 3));
        rd(2'd3, v); chk("R9 free count after 5 pushes", {25'd0, v[30:24]}, 59);
        chk("R12 dma off below free threshold", {31'd0, dma_req}, 0);
        wr(2'd1, 32'd3);
        wr(2'd2, 32'd1);
        dev_ack = 1'b1;
        wait_idle();
        dev_ack = 1'b0;
        chk("R10 done pulse write mode", done_cnt, 2);
        rd(2'd3, v);
        chk("R7 R8 remaining zero", {18'd0, v[13:0]}, 0);
        chk("R9 free count after 3 posted", {25'd0, v[30:24]}, 62);
        chk("R7 two bytes left queued", wq.size(), 2);

        // R11 stop without done
        wr(2'd1, 32'd10);
        wr(2'd2, 32'd1);
        rd(2'd2, v); chk("R5 restart busy", v, 1);
        wr(2'd2, 32'd0);
        rd(2'd2, v); chk("R11 stop clears busy", v, 0);
        repeat (2) @(posedge clk);
        #1;
        chk("R11 no done on stop", done_cnt, 2);

        // R5 ignored starts
        wr(2'd0, 32'h0);
        wq.delete();
        wr(2'd2, 32'd1);
        rd(2'd2, v); chk("R5 start ignored when disabled", v, 0);
        wr(2'd0, 32'h0000_0080);
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd1);
        rd(2'd2, v); chk("R5 start ignored with zero count", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule